// File: doc/BRIEF.md
# Canonical Signed Digit Encoder

This block rewrites a two's complement integer of configurable width into canonical signed digit form. Each output digit is -1, 0 or +1. The digits are weighted by powers of two and sum back to the input value. No two neighbouring digits are both nonzero, so the count of nonzero digits is as small as it can be. A constant-coefficient shift-and-add multiplier needs one add or subtract per nonzero digit, so a coefficient compiler or a run-time coefficient loader uses this form to pick the fewest operations.

The conversion is serial and produces one digit per clock, starting at the least significant position. A load strobe captures the value and extends its sign by one bit. Each later cycle examines two adjacent bits of the value and a running carry. Each digit appears on a streaming output with its position. The digits are also collected into a parallel word. When the last digit is produced, a done pulse marks the word as complete, and a count of its nonzero digits is presented with it.

Top module: `csd_encoder`

## Requirements
- R1: After reset, dig_valid_o and done_o are 0, csd_word_o is all zeros and nz_count_o is 0.
- R2: A load accepted on a clock edge makes the digit for position i appear on the (i+1)-th following edge, with dig_valid_o high and dig_idx_o = i. Digits appear least significant first, exactly W of them in consecutive cycles, and dig_valid_o then returns to 0.
- R3: Digit codes are 2'b00 for 0, 2'b01 for +1 and 2'b11 for -1. Code 2'b10 never appears on dig_code_o or in csd_word_o.
- R4: The sum over i of digit(i)·2^i equals the signed input value.
- R5: No two adjacent digit positions are both nonzero.
- R6: done_o is high for exactly one cycle, in the same cycle as the digit with index W-1.
- R7: csd_word_o bits [2i+1:2i] hold the code of digit i. The word is complete when done_o rises and holds its value until the next load, which clears it.
- R8: When done_o is high, nz_count_o equals the number of nonzero digits in csd_word_o. It holds that value until the next load, which clears it to 0.
- R9: A load while a conversion is running abandons that conversion. It restarts from digit 0 with a zero carry, using the new value, and clears the word and the count.
- R10: Extreme inputs are encoded correctly using the one-bit sign extension: the most negative value, -1, the largest positive value, and alternating bit patterns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| load_i | input | 1 | Start a conversion of value_i (restarts one in progress) |
| value_i | input | W | Two's complement value to encode |
| dig_valid_o | output | 1 | A digit is present on dig_code_o this cycle |
| dig_code_o | output | 2 | Digit code: 00 zero, 01 plus one, 11 minus one |
| dig_idx_o | output | $clog2(W) | Position of the present digit |
| done_o | output | 1 | One-cycle pulse with the last digit |
| csd_word_o | output | 2W | All digit codes, digit i at bits [2i+1:2i] |
| nz_count_o | output | $clog2(W+1) | Number of nonzero digits of the finished word |

## Verification
The hardest case to reach is a carry that has to cross a long run of ones, or reach the extended sign bit. This happens with values such as the largest positive number, 0x6666 patterns and the most negative number, so the stimulus uses these values on purpose as well as random ones. The other hard case is a load arriving in the middle of a conversion while the carry is set. To reach it, the bench starts a value that produces carries and reloads it after a few digits. It then requires a clean restart with cleared word and count.

// File: rtl/csd_pkg.sv
`timescale 1ns/1ps
package csd_pkg;
  typedef logic [1:0] digit_t;
  localparam digit_t DIG_ZERO = 2'b00;
  localparam digit_t DIG_POS  = 2'b01;
  localparam digit_t DIG_NEG  = 2'b11;
endpackage

// File: rtl/csd_digit_lut.sv
`timescale 1ns/1ps
// Digit selection from two adjacent value bits and the incoming carry.
module csd_digit_lut
  import csd_pkg::*;
(
  input  logic   bit_hi_i,
  input  logic   bit_lo_i,
  input  logic   carry_i,
  output digit_t code_o,
  output logic   carry_o
);
  logic [2:0] sel;
  assign sel = {bit_hi_i, bit_lo_i, carry_i};

  always_comb begin
    unique case (sel)
      3'd1, 3'd2: begin code_o = DIG_POS;  carry_o = 1'b0; end
      3'd3, 3'd7: begin code_o = DIG_ZERO; carry_o = 1'b1; end
      3'd5, 3'd6: begin code_o = DIG_NEG;  carry_o = 1'b1; end
      default:    begin code_o = DIG_ZERO; carry_o = 1'b0; end
    endcase
  end
endmodule

// File: rtl/csd_ctrl.sv
`timescale 1ns/1ps
// Holds the sign-extended value, the carry and the position counter.
module csd_ctrl #(
  parameter int W  = 16,
  parameter int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic [W-1:0]  value_i,
  input  logic          carry_nxt_i,
  output logic          bit_hi_o,
  output logic          bit_lo_o,
  output logic          carry_o,
  output logic          step_o,
  output logic          last_o,
  output logic [IW-1:0] pos_o
);
  localparam logic [IW-1:0] LAST = IW'(W - 1);

  logic [W:0]    sreg_q;
  logic          carry_q;
  logic          run_q;
  logic [IW-1:0] pos_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg_q  <= '0;
      carry_q <= 1'b0;
      run_q   <= 1'b0;
      pos_q   <= '0;
    end else if (load_i) begin
      sreg_q  <= {value_i[W-1], value_i};
      carry_q <= 1'b0;
      run_q   <= 1'b1;
      pos_q   <= '0;
    end else if (run_q) begin
      sreg_q  <= {sreg_q[W], sreg_q[W:1]};
      carry_q <= carry_nxt_i;
      pos_q   <= pos_q + 1'b1;
      if (pos_q == LAST) run_q <= 1'b0;
    end
  end

  assign bit_hi_o = sreg_q[1];
  assign bit_lo_o = sreg_q[0];
  assign carry_o  = carry_q;
  assign step_o   = run_q;
  assign last_o   = run_q && (pos_q == LAST);
  assign pos_o    = pos_q;

  // A fresh load always starts at digit 0 with no carry pending
  assert_restart_clean_R9: assert property (@(posedge clk) disable iff (rst)
    load_i |=> (!carry_q && pos_q == '0 && run_q));
endmodule

// File: rtl/csd_gather.sv
`timescale 1ns/1ps
// Registered digit stream, parallel word and nonzero count.
module csd_gather
  import csd_pkg::*;
#(
  parameter int W  = 16,
  parameter int IW = (W > 1) ? $clog2(W) : 1,
  parameter int CW = $clog2(W + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic          step_i,
  input  logic          last_i,
  input  logic [IW-1:0] pos_i,
  input  digit_t        code_i,
  output logic          dig_valid_o,
  output digit_t        dig_code_o,
  output logic [IW-1:0] dig_idx_o,
  output logic          done_o,
  output logic [2*W-1:0] word_o,
  output logic [CW-1:0] count_o
);
  localparam logic [CW-1:0] MAX_NZ = CW'((W + 1) / 2);

  always_ff @(posedge clk) begin
    if (rst) begin
      dig_valid_o <= 1'b0;
      dig_code_o  <= DIG_ZERO;
      dig_idx_o   <= '0;
      done_o      <= 1'b0;
      word_o      <= '0;
      count_o     <= '0;
    end else if (load_i) begin
      dig_valid_o <= 1'b0;
      done_o      <= 1'b0;
      word_o      <= '0;
      count_o     <= '0;
    end else begin
      dig_valid_o <= step_i;
      done_o      <= step_i && last_i;
      if (step_i) begin
        dig_code_o                   <= code_i;
        dig_idx_o                    <= pos_i;
        word_o[2*int'(pos_i) +: 2]   <= code_i;
        count_o                      <= count_o + CW'(code_i[0]);
      end
    end
  end

  // Canonical form never needs more than half the positions (rounded up)
  assert_count_bound_R8: assert property (@(posedge clk) disable iff (rst)
    count_o <= MAX_NZ);
  // Word and count are frozen between the end of a conversion and the next load
  assert_word_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!step_i && !load_i) |=> ($stable(word_o) && $stable(count_o)));
endmodule

// File: rtl/csd_encoder.sv
`timescale 1ns/1ps
module csd_encoder
  import csd_pkg::*;
#(
  parameter int W  = 16,
  parameter int IW = (W > 1) ? $clog2(W) : 1,
  parameter int CW = $clog2(W + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load_i,
  input  logic [W-1:0]   value_i,
  output logic           dig_valid_o,
  output logic [1:0]     dig_code_o,
  output logic [IW-1:0]  dig_idx_o,
  output logic           done_o,
  output logic [2*W-1:0] csd_word_o,
  output logic [CW-1:0]  nz_count_o
);
  logic          bit_hi, bit_lo, carry, carry_nxt, step, last;
  logic [IW-1:0] pos;
  digit_t        code;

  csd_ctrl #(.W(W), .IW(IW)) u_ctrl (
    .clk(clk), .rst(rst), .load_i(load_i), .value_i(value_i),
    .carry_nxt_i(carry_nxt), .bit_hi_o(bit_hi), .bit_lo_o(bit_lo),
    .carry_o(carry), .step_o(step), .last_o(last), .pos_o(pos)
  );

  csd_digit_lut u_lut (
    .bit_hi_i(bit_hi), .bit_lo_i(bit_lo), .carry_i(carry),
    .code_o(code), .carry_o(carry_nxt)
  );

  csd_gather #(.W(W), .IW(IW), .CW(CW)) u_gather (
    .clk(clk), .rst(rst), .load_i(load_i), .step_i(step), .last_i(last),
    .pos_i(pos), .code_i(code), .dig_valid_o(dig_valid_o),
    .dig_code_o(dig_code_o), .dig_idx_o(dig_idx_o), .done_o(done_o),
    .word_o(csd_word_o), .count_o(nz_count_o)
  );

  assert_code_legal_R3: assert property (@(posedge clk) disable iff (rst)
    dig_valid_o |-> (dig_code_o != 2'b10));
  assert_idx_step_R2: assert property (@(posedge clk) disable iff (rst)
    (dig_valid_o && dig_idx_o != '0) |->
      ($past(dig_valid_o) && dig_idx_o == $past(dig_idx_o) + 1'b1));
  assert_no_adjacent_R5: assert property (@(posedge clk) disable iff (rst)
    (dig_valid_o && $past(dig_valid_o) && dig_idx_o != '0 && dig_code_o != DIG_ZERO)
      |-> ($past(dig_code_o) == DIG_ZERO));
  assert_done_last_R6: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (dig_valid_o && dig_idx_o == IW'(W - 1)));
  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
endmodule

// File: tb/sim_csd_encoder.sv
`timescale 1ns/1ps
module sim_csd_encoder;
  localparam int W  = 16;
  localparam int IW = $clog2(W);
  localparam int CW = $clog2(W + 1);

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           load = 1'b0;
  logic [W-1:0]   value = '0;
  logic           dig_valid;
  logic [1:0]     dig_code;
  logic [IW-1:0]  dig_idx;
  logic           done;
  logic [2*W-1:0] word;
  logic [CW-1:0]  nzc;

  int total = 0;
  int fails = 0;

  always #4 clk = ~clk;

  csd_encoder #(.W(W)) u0 (
    .clk(clk), .rst(rst), .load_i(load), .value_i(value),
    .dig_valid_o(dig_valid), .dig_code_o(dig_code), .dig_idx_o(dig_idx),
    .done_o(done), .csd_word_o(word), .nz_count_o(nzc)
  );

  // Behavioural reference: non-adjacent form by repeated halving
  longint         m_rem;
  bit             m_run, m_vld, m_done;
  int             m_pos, m_idx, m_cnt;
  logic [1:0]     m_code;
  logic [2*W-1:0] m_word;

  always @(posedge clk) begin
    if (rst) begin
      m_run = 0; m_vld = 0; m_done = 0; m_pos = 0; m_idx = 0;
      m_cnt = 0; m_code = 2'b00; m_word = '0; m_rem = 0;
    end else if (load) begin
      m_rem = longint'($signed(value));
      m_run = 1; m_pos = 0; m_vld = 0; m_done = 0; m_word = '0; m_cnt = 0;
    end else if (m_run) begin
      int d;
      d = 0;
      if ((m_rem & 1) != 0) d = ((m_rem & 3) == 1) ? 1 : -1;
      m_rem  = (m_rem - d) >>> 1;
      m_code = (d == 0) ? 2'b00 : (d == 1) ? 2'b01 : 2'b11;
      m_vld  = 1; m_idx = m_pos;
      m_word[2*m_pos +: 2] = m_code;
      if (d != 0) m_cnt++;
      m_done = (m_pos == W - 1);
      m_pos++;
      if (m_pos == W) m_run = 0;
    end else begin
      m_vld = 0; m_done = 0;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the reference
  always @(negedge clk) begin
    if (!rst) begin
      chk(dig_valid == m_vld, "R2 valid", longint'(dig_valid), longint'(m_vld));
      if (m_vld) begin
        chk(int'(dig_idx) == m_idx, "R2 index", longint'(dig_idx), longint'(m_idx));
        chk(dig_code == m_code, "R3 code", longint'(dig_code), longint'(m_code));
      end
      chk(done == m_done, "R6 done", longint'(done), longint'(m_done));
      chk(word == m_word, "R7 word", longint'(word), longint'(m_word));
      if (m_done || !m_run)
        chk(int'(nzc) == m_cnt, "R8 count", longint'(nzc), longint'(m_cnt));
    end
  end

  task automatic do_load(input logic [W-1:0] v);
    @(negedge clk); load = 1'b1; value = v;
    @(negedge clk); load = 1'b0; value = ~v;
  endtask

  // Checks on the finished word taken at the ports
  task automatic check_final(input logic [W-1:0] v);
    longint sum = 0;
    int nz = 0;
    bit adj = 0, bad = 0, prev = 0;
    chk(done == 1'b1, "R6 done at end", longint'(done), 1);
    for (int i = 0; i < W; i++) begin
      logic [1:0] c = word[2*i +: 2];
      int d = (c == 2'b01) ? 1 : (c == 2'b11) ? -1 : 0;
      if (c == 2'b10) bad = 1;
      if (d != 0 && prev) adj = 1;
      prev = (d != 0);
      if (d != 0) nz++;
      sum += longint'(d) * (longint'(1) << i);
    end
    chk(!bad, "R3 no code 10", longint'(bad), 0);
    chk(sum == longint'($signed(v)), "R4 weighted sum", sum, longint'($signed(v)));
    chk(!adj, "R5 adjacency", longint'(adj), 0);
    chk(int'(nzc) == nz, "R8 nonzero count", longint'(nzc), longint'(nz));
  endtask

  task automatic run_value(input logic [W-1:0] v);
    do_load(v);
    repeat (W) @(negedge clk);
    check_final(v);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!dig_valid && !done, "R1 reset flags", longint'({dig_valid, done}), 0);
    chk(word == '0 && nzc == '0, "R1 reset word", longint'(word), 0);
    @(negedge clk); rst = 1'b0;

    run_value(16'h0000);
    run_value(16'h0001);
    run_value(16'hFFFF);               // R10 minus one
    run_value(16'h7FFF);               // R10 largest positive
    run_value(16'h8000);               // R10 most negative
    run_value(16'h5555);               // R10 alternating
    run_value(16'hAAAA);
    run_value(16'h6666);
    run_value(16'h3C3C);
    // R7/R8 hold: idle cycles after done, word and count must stay
    repeat (5) @(negedge clk);
    // R9: reload mid-conversion with a carry pending
    do_load(16'h7777);
    repeat (5) @(negedge clk);
    run_value(16'h1234);
    do_load(16'hBEEF);
    repeat (W - 1) @(negedge clk);
    run_value(16'h8001);               // reload on the last digit cycle
    for (int k = 0; k < 40; k++) run_value(W'($urandom));
    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #(8 * 200000);
    fails++; total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule